// File: doc/BRIEF.md
# Variable-Length Instruction Predecoder

This block sits between an instruction fetch queue and the decode stage of a 16-bit RISC core. Most instructions are one 16-bit halfword. A few upper-byte values of a first halfword act as escape prefixes: they announce that the next halfword belongs to the same 32-bit instruction. The predecoder accepts halfwords one at a time over a valid/ready handshake. For each instruction it produces one record: the length, the assembled word, and a class tag saying which prefix started it.

When a prefix halfword arrives, the block keeps it internally and emits nothing until the partner halfword has been accepted. The finished record sits in a single output register until the consumer takes it. While that register is occupied and the consumer stalls, the input side is held off. A flush input drops a half-built instruction, for example after a branch redirect. The prefix with upper byte 0x82 is recognised only while a configuration input enables it.

Top module: `vlp_predecode`

## Requirements
- R1: An accepted halfword whose upper byte is not an enabled prefix yields one record one cycle later. The record has out_len32=0, out_class=0 (none), and out_word = {16'h0000, halfword}.
- R2: A first halfword with upper byte 0x8A starts a 32-bit instruction tagged out_class=1.
- R3: A first halfword with upper byte 0x8C starts a 32-bit instruction tagged out_class=2.
- R4: A first halfword with upper byte 0x8E starts a 32-bit instruction tagged out_class=3.
- R5: Upper byte 0x82 starts a 32-bit instruction tagged out_class=4 only when cfg_wide82_en=1 at the cycle the halfword is accepted. Otherwise it is handled as in R1.
- R6: A 32-bit record has out_len32=1. Its out_word holds the first halfword in bits [31:16] and the second in bits [15:0].
- R7: After a prefix halfword, no record appears until a second halfword is accepted. That second halfword is taken as-is, even if its upper byte matches a prefix.
- R8: While flush=1, in_ready is 0 and any held prefix is discarded. The next accepted halfword starts a fresh instruction. A record already in the output register is not affected.
- R9: While out_valid=1 and out_ready=0, in_ready is 0 and the record on the outputs stays unchanged. In every other cycle without flush, in_ready is 1.
- R10: Every instruction appears exactly once, in arrival order, whatever the pattern of stalls on either side.
- R11: During reset, and right after it is released, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| cfg_wide82_en | input | 1 | Enables upper byte 0x82 as a prefix |
| flush | input | 1 | Drops a held prefix and blocks input for the cycle |
| in_valid | input | 1 | A halfword is offered |
| in_half | input | 16 | Offered halfword |
| in_ready | output | 1 | The halfword is taken at this edge when in_valid=1 |
| out_valid | output | 1 | A record is presented |
| out_ready | input | 1 | Consumer takes the record at this edge |
| out_len32 | output | 1 | 1 for a 32-bit instruction, 0 for 16-bit |
| out_word | output | 32 | Assembled instruction word |
| out_class | output | 3 | 0 none, 1 0x8A, 2 0x8C, 3 0x8E, 4 0x82 |

## Verification
A record becomes visible on the outputs in the cycle after the edge that accepted its last halfword. A prefix halfword produces nothing on its own. in_ready is a combinational function of flush, out_ready and the occupancy of the output register, so it is due in the same cycle as the inputs that cause it. The bench drives inputs just after the falling edge and lets them settle. It then compares in_ready and the output record with a queue model that pushes a record when the completing halfword is taken and pops it when the consumer takes it, and it does this every cycle. The queue therefore enforces both the one-cycle latency and the order.

// File: rtl/vlp_pkg.sv
`timescale 1ns/1ps
package vlp_pkg;

  // number of escape prefixes the classifier knows about
  localparam int VLP_NUM_PFX = 4;

  // class tag carried with each record; 0 marks a plain 16-bit instruction
  typedef enum logic [2:0] {
    VLP_CLS_NONE    = 3'd0,
    VLP_CLS_IMM24   = 3'd1,
    VLP_CLS_SHORTLD = 3'd2,
    VLP_CLS_WIDE_E  = 3'd3,
    VLP_CLS_WIDE_2  = 3'd4
  } vlp_cls_e;

  // tag belonging to prefix slot idx (slot order matches the prefix vector)
  function automatic vlp_cls_e vlp_tag_of(input int idx);
    case (idx)
      0:       return VLP_CLS_IMM24;
      1:       return VLP_CLS_SHORTLD;
      2:       return VLP_CLS_WIDE_E;
      3:       return VLP_CLS_WIDE_2;
      default: return VLP_CLS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/vlp_classify.sv
`timescale 1ns/1ps
// Looks at the upper byte of a halfword and reports whether it opens a
// 32-bit instruction, and with which class tag.
module vlp_classify
  import vlp_pkg::*;
#(
  parameter int          HALF_W      = 16,
  parameter int          PFX_W       = 8,
  parameter logic [PFX_W-1:0] PFX_IMM24   = 8'h8A,
  parameter logic [PFX_W-1:0] PFX_SHORTLD = 8'h8C,
  parameter logic [PFX_W-1:0] PFX_WIDE_E  = 8'h8E,
  parameter logic [PFX_W-1:0] PFX_WIDE_2  = 8'h82
) (
  input  logic [HALF_W-1:0] half_i,
  input  logic              wide2_en_i,
  output logic              is_prefix_o,
  output vlp_cls_e          cls_o
);

  localparam logic [VLP_NUM_PFX*PFX_W-1:0] PFX_VEC =
    {PFX_WIDE_2, PFX_WIDE_E, PFX_SHORTLD, PFX_IMM24};

  logic [PFX_W-1:0]       top_byte;
  logic [VLP_NUM_PFX-1:0] allow;
  logic [VLP_NUM_PFX-1:0] hit;

  assign top_byte = half_i[HALF_W-1 -: PFX_W];
  // only the last slot is switchable
  assign allow    = {wide2_en_i, {(VLP_NUM_PFX-1){1'b1}}};

  for (genvar g = 0; g < VLP_NUM_PFX; g++) begin : g_match
    assign hit[g] = allow[g] && (top_byte == PFX_VEC[g*PFX_W +: PFX_W]);
  end

  always_comb begin
    is_prefix_o = |hit;
    cls_o       = VLP_CLS_NONE;
    for (int i = VLP_NUM_PFX - 1; i >= 0; i--) begin
      if (hit[i]) cls_o = vlp_tag_of(i);
    end
  end

endmodule

// File: rtl/vlp_assemble.sv
`timescale 1ns/1ps
// Holds a prefix halfword and pairs it with its partner; produces one
// emit pulse per finished instruction.
module vlp_assemble
  import vlp_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              flush_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              is_prefix_i,
  input  vlp_cls_e          cls_i,
  output logic              emit_o,
  output logic [WORD_W-1:0] emit_word_o,
  output logic              emit_len32_o,
  output vlp_cls_e          emit_cls_o
);

  logic              held_q, held_d;
  logic              hold_load;
  logic [HALF_W-1:0] held_half_q;
  vlp_cls_e          held_cls_q;

  // next state of the holding flag
  always_comb begin
    held_d    = held_q;
    hold_load = 1'b0;
    if (flush_i) begin
      held_d = 1'b0;
    end else if (accept_i) begin
      if (held_q) begin
        held_d = 1'b0;
      end else if (is_prefix_i) begin
        held_d    = 1'b1;
        hold_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  // data registers carry no reset; they are read only while held_q is set
  always_ff @(posedge clk) begin
    if (hold_load) begin
      held_half_q <= half_i;
      held_cls_q  <= cls_i;
    end
  end

  always_comb begin
    emit_o = accept_i && (held_q || !is_prefix_i);
    if (held_q) begin
      emit_word_o  = {held_half_q, half_i};
      emit_len32_o = 1'b1;
      emit_cls_o   = held_cls_q;
    end else begin
      emit_word_o  = {{HALF_W{1'b0}}, half_i};
      emit_len32_o = 1'b0;
      emit_cls_o   = VLP_CLS_NONE;
    end
  end

endmodule

// File: rtl/vlp_outreg.sv
`timescale 1ns/1ps
// Single-entry output register with valid/ready.
module vlp_outreg
  import vlp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              len32_i,
  input  vlp_cls_e          cls_i,
  input  logic              out_ready_i,
  output logic              slot_free_o,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_word_o,
  output logic              out_len32_o,
  output vlp_cls_e          out_cls_o
);

  logic ov_q, ov_d;

  always_comb begin
    ov_d = ov_q;
    if (load_i)                  ov_d = 1'b1;
    else if (ov_q && out_ready_i) ov_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= 1'b0;
    else        ov_q <= ov_d;
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      out_word_o  <= word_i;
      out_len32_o <= len32_i;
      out_cls_o   <= cls_i;
    end
  end

  assign slot_free_o = !ov_q || out_ready_i;
  assign out_valid_o = ov_q;

endmodule

// File: rtl/vlp_predecode.sv
`timescale 1ns/1ps
module vlp_predecode
  import vlp_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PFX_W  = 8,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide82_en,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [HALF_W-1:0] in_half,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_len32,
  output logic [WORD_W-1:0] out_word,
  output logic [2:0]        out_class
);

  logic              is_prefix;
  vlp_cls_e          pfx_cls;
  logic              slot_free;
  logic              accept;
  logic              emit;
  logic [WORD_W-1:0] emit_word;
  logic              emit_len32;
  vlp_cls_e          emit_cls;
  vlp_cls_e          out_cls;

  assign in_ready = slot_free && !flush;
  assign accept   = in_valid && in_ready;

  vlp_classify #(
    .HALF_W (HALF_W),
    .PFX_W  (PFX_W)
  ) u_classify (
    .half_i      (in_half),
    .wide2_en_i  (cfg_wide82_en),
    .is_prefix_o (is_prefix),
    .cls_o       (pfx_cls)
  );

  vlp_assemble #(
    .HALF_W (HALF_W)
  ) u_assemble (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept),
    .flush_i      (flush),
    .half_i       (in_half),
    .is_prefix_i  (is_prefix),
    .cls_i        (pfx_cls),
    .emit_o       (emit),
    .emit_word_o  (emit_word),
    .emit_len32_o (emit_len32),
    .emit_cls_o   (emit_cls)
  );

  vlp_outreg #(
    .WORD_W (WORD_W)
  ) u_outreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (emit),
    .word_i      (emit_word),
    .len32_i     (emit_len32),
    .cls_i       (emit_cls),
    .out_ready_i (out_ready),
    .slot_free_o (slot_free),
    .out_valid_o (out_valid),
    .out_word_o  (out_word),
    .out_len32_o (out_len32),
    .out_cls_o   (out_cls)
  );

  assign out_class = out_cls;

endmodule

// File: rtl/vlp_predecode_chk.sv
`timescale 1ns/1ps
module vlp_predecode_chk #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_len32,
  input logic [WORD_W-1:0] out_word,
  input logic [2:0]        out_class
);

  AST_SHORT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_len32 |-> out_class == 3'd0 && out_word[WORD_W-1:HALF_W] == '0) // R1
    else $error("short record malformed");

  AST_TAG_8A: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd1 |-> out_len32 && out_word[WORD_W-1 -: 8] == 8'h8A) // R2
    else $error("class 1 mismatch");

  AST_TAG_8C: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd2 |-> out_len32 && out_word[WORD_W-1 -: 8] == 8'h8C) // R3
    else $error("class 2 mismatch");

  AST_TAG_8E: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd3 |-> out_len32 && out_word[WORD_W-1 -: 8] == 8'h8E) // R4
    else $error("class 3 mismatch");

  AST_TAG_82: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd4 |-> out_len32 && out_word[WORD_W-1 -: 8] == 8'h82) // R5
    else $error("class 4 mismatch");

  AST_WIDE_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_len32 |-> out_class != 3'd0) // R6
    else $error("wide record without tag");

  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready) // R8
    else $error("ready during flush");

  AST_BP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready) // R9
    else $error("ready under backpressure");

  AST_BP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_len32) && $stable(out_class)) // R9
    else $error("record changed while stalled");

endmodule

bind vlp_predecode vlp_predecode_chk #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_len32 (out_len32),
  .out_word  (out_word),
  .out_class (out_class)
);

// File: tb/vlp_predecode_bench.sv
`timescale 1ns/1ps
module vlp_predecode_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_wide82_en;
  logic        flush;
  logic        in_valid;
  logic [15:0] in_half;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready;
  logic        out_len32;
  logic [31:0] out_word;
  logic [2:0]  out_class;

  vlp_predecode u_vlp_predecode (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wide82_en (cfg_wide82_en),
    .flush         (flush),
    .in_valid      (in_valid),
    .in_half       (in_half),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_len32     (out_len32),
    .out_word      (out_word),
    .out_class     (out_class)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [31:0] w;
    bit          l;
    logic [2:0]  c;
  } rec_t;

  rec_t        q[$];
  bit          m_held;
  logic [15:0] m_first;
  logic [2:0]  m_cls;
  int          n_checks;
  int          n_err;
  bit          done;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // class a first halfword opens, from the requirements; 0 means plain
  function automatic logic [2:0] spec_cls(input logic [15:0] h, input bit en82);
    case (h[15:8])
      8'h8A:   return 3'd1;
      8'h8C:   return 3'd2;
      8'h8E:   return 3'd3;
      8'h82:   return en82 ? 3'd4 : 3'd0;
      default: return 3'd0;
    endcase
  endfunction

  function automatic string cls_req(input logic [2:0] c);
    case (c)
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      3'd4:    return "R5";
      default: return "R1";
    endcase
  endfunction

  // one cycle: drive at the falling edge, compare, advance the model
  task automatic step(input bit iv, input logic [15:0] h, input bit ordy,
                      input bit fl, input bit en82);
    bit exp_ready;
    bit pending;
    in_valid      = iv;
    in_half       = h;
    out_ready     = ordy;
    flush         = fl;
    cfg_wide82_en = en82;
    #1;
    pending   = (q.size() > 0);
    exp_ready = !fl && !(pending && !ordy);
    chk(in_ready == exp_ready, fl ? "R8" : "R9", "in_ready", in_ready, exp_ready);
    chk(out_valid == pending, m_held ? "R7" : "R10", "out_valid", out_valid, pending);
    if (pending && out_valid) begin
      chk(out_word == q[0].w, q[0].l ? "R6" : "R1", "out_word", out_word, q[0].w);
      chk(out_len32 == q[0].l, "R6", "out_len32", out_len32, q[0].l);
      chk(out_class == q[0].c, cls_req(q[0].c), "out_class", out_class, q[0].c);
    end
    if (pending && ordy) void'(q.pop_front());
    if (fl) begin
      m_held = 1'b0;
    end else if (iv && exp_ready) begin
      rec_t r;
      if (m_held) begin
        r.w = {m_first, h}; r.l = 1'b1; r.c = m_cls;
        q.push_back(r);
        m_held = 1'b0;
      end else if (spec_cls(h, en82) != 3'd0) begin
        m_held  = 1'b1;
        m_first = h;
        m_cls   = spec_cls(h, en82);
      end else begin
        r.w = {16'h0000, h}; r.l = 1'b0; r.c = 3'd0;
        q.push_back(r);
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 1'b1, 1'b0, 1'b0);
  endtask

  function automatic logic [15:0] rand_half();
    logic [15:0] v;
    v = 16'($urandom);
    case ($urandom % 6)
      0: v[15:8] = 8'h8A;
      1: v[15:8] = 8'h8C;
      2: v[15:8] = 8'h8E;
      3: v[15:8] = 8'h82;
      default: ;
    endcase
    return v;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_err = 0; done = 1'b0; m_held = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_half = '0; out_ready = 1'b1;
    flush = 1'b0; cfg_wide82_en = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R11", "in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);
    @(negedge clk);

    // R1: plain halfwords back to back
    step(1, 16'h1234, 1, 0, 0);
    step(1, 16'h7F00, 1, 0, 0);
    step(1, 16'h8BFF, 1, 0, 0);
    idle(2);
    // R2 R3 R4: each prefix with its partner
    step(1, 16'h8A12, 1, 0, 0); step(1, 16'h3456, 1, 0, 0);
    step(1, 16'h8C01, 1, 0, 0); step(1, 16'hABCD, 1, 0, 0);
    step(1, 16'h8EFF, 1, 0, 0); step(1, 16'h0001, 1, 0, 0);
    idle(2);
    // R5: 0x82 disabled then enabled
    step(1, 16'h8255, 1, 0, 0);
    step(1, 16'h8266, 1, 0, 1); step(1, 16'h1111, 1, 0, 1);
    idle(2);
    // R7: prefix, gap, then a prefix-looking partner taken raw
    step(1, 16'h8A00, 1, 0, 0);
    idle(3);
    step(1, 16'h8E77, 1, 0, 0);
    idle(2);
    // R8: flush drops a held prefix; next halfword decoded fresh
    step(1, 16'h8C42, 1, 0, 0);
    step(0, 16'h0000, 1, 1, 0);
    step(1, 16'h2222, 1, 0, 0);
    #1;
    chk(out_valid && !out_len32 && out_word == 32'h0000_2222, "R8",
        "fresh after flush", out_word, 32'h0000_2222);
    @(negedge clk);
    // R8: flush while a record waits leaves it intact
    step(1, 16'h3333, 0, 0, 0);
    step(1, 16'h4444, 0, 1, 0);
    step(0, 16'h0000, 1, 0, 0);
    idle(1);
    // R9: long stall with input offered
    step(1, 16'h8E10, 1, 0, 0);
    step(1, 16'h2020, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 16'h5555, 0, 0, 0);
    idle(3);
    // R10: random traffic with stalls on both sides
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, rand_half(), ($urandom % 3) != 0,
           ($urandom % 40) == 0, ($urandom % 2) == 0);
    idle(4);
    chk(q.size() == 0, "R10", "records left over", q.size(), 0);

    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule